// File: doc/BRIEF.md
# SPI Paged Register Target

This block is the device end of a byte-wide SPI register link whose address space is reached indirectly through pages. Each frame, bounded by chip select, opens with a command byte that says read or write. An offset byte follows, and it names a location inside the page chosen earlier. Three offsets are reserved: a page-select register, a status register and a data window. Every other offset addresses an ordinary register in a small internal store.

A write frame carries its data bytes right after the offset, least significant byte first. A read of an ordinary register does not return its value in the same frame. It starts a fetch that takes a fixed number of clocks. While the fetch runs, a busy flag shows in the status register. When the fetch ends, a read-acknowledge flag is set. The host then reads the value, least significant byte first, through the data window in a later frame.

The SPI pins are sampled by the system clock through synchronizers, so the SPI clock must be several times slower than the system clock.

Top module: `spi_paged_regtarget`

## Requirements
- R1: A command byte is accepted only when bits 7..1 equal 0x60 >> 1. Bit 0 selects write (1) or read (0). A frame with any other command byte writes nothing and returns zero bytes.
- R2: Writing one data byte to offset 0xFF sets the page used by every later ordinary access. A read frame to 0xFF returns the current page.
- R3: A read of offset 0xFE returns status. Bit 7 is the fetch-busy flag, bit 5 is the read-acknowledge flag, and all other bits are zero. The two flags are never set together.
- R4: A read frame to an ordinary offset starts a fetch. Busy is set and acknowledge is cleared from the next clock, and busy stays set for FETCH_LAT clocks.
- R5: When a fetch ends, busy clears and acknowledge is set. The fetched 64-bit value is then held in the data window.
- R6: A read frame to offset 0xF0 returns the window bytes in order from byte 0 (least significant) to byte 7. Any byte after the eighth reads as zero.
- R7: A window read while acknowledge is low returns only zero bytes.
- R8: In a write frame to an ordinary offset, data byte k updates byte lane k of the register, for k = 0 to 7. Lanes that are not sent keep their value, and data bytes after the eighth are dropped.
- R9: SPI mode 0 is used, most significant bit first, and MISO is low outside a frame. Raising chip select discards a partial byte and makes the next byte a command byte.
- R10: An ordinary access whose page is at least NUM_PAGES, or whose offset is at least REGS_PER_PAGE, writes nothing. A fetch from such an address still completes and returns zero.
- R11: Write frames to offsets 0xFE and 0xF0 change neither the status nor the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low, bounds one frame |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |

## Verification
A wrong byte position inside a frame shows up as a shifted or misplaced byte on MISO during the very next window, page or status read. It can also appear as a corrupted lane on the following fetch. A stuck or early busy/acknowledge flag shows up in the first status read after a fetch starts, and again after the fetch completes, within one frame of the error. Lane wrap-around and address decoding faults stay hidden until a fetch of the affected register has been read back through the window. For that reason, every write in the sequence is followed by a fetch and a window read.

// File: rtl/sprt_pkg.sv
package sprt_pkg;
  localparam int unsigned WIN_BYTES = 8;
  localparam int unsigned WIN_W     = WIN_BYTES * 8;
  localparam int unsigned LANE_W    = $clog2(WIN_BYTES);

  localparam logic [7:0] CMD_BASE = 8'h60;
  localparam logic [7:0] OFF_PAGE = 8'hFF;
  localparam logic [7:0] OFF_STAT = 8'hFE;
  localparam logic [7:0] OFF_WIN  = 8'hF0;

  localparam int unsigned STAT_BUSY_BIT = 7;
  localparam int unsigned STAT_ACK_BIT  = 5;

  typedef enum logic [1:0] {
    RSP_NONE,
    RSP_PAGE,
    RSP_STAT,
    RSP_WIN
  } rsp_sel_e;

  function automatic logic is_plain(input logic [7:0] off);
    return (off != OFF_PAGE) && (off != OFF_STAT) && (off != OFF_WIN);
  endfunction
endpackage

// File: rtl/sprt_spi_shifter.sv
module sprt_spi_shifter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       miso,
  output logic       frame_active,
  output logic       rx_valid,
  output logic [7:0] rx_byte
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclk_s, cs_s, mosi_s;
  logic                   sclk_prev_q;
  logic [2:0]             bit_cnt_q, bit_cnt_d;
  logic [7:0]             rx_sr_q, rx_sr_d;
  logic [7:0]             tx_sr_q, tx_sr_d;
  logic                   rx_valid_q, rx_valid_d;
  logic                   rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s      <= '0;
      cs_s        <= '1;
      mosi_s      <= '0;
      sclk_prev_q <= 1'b0;
    end else begin
      sclk_s      <= {sclk_s[SYNC_STAGES-2:0], sclk};
      cs_s        <= {cs_s[SYNC_STAGES-2:0], cs_n};
      mosi_s      <= {mosi_s[SYNC_STAGES-2:0], mosi};
      sclk_prev_q <= sclk_s[MSB];
    end
  end

  assign frame_active = ~cs_s[MSB];
  assign rise = frame_active &  sclk_s[MSB] & ~sclk_prev_q;
  assign fall = frame_active & ~sclk_s[MSB] &  sclk_prev_q;

  always_comb begin
    bit_cnt_d  = bit_cnt_q;
    rx_sr_d    = rx_sr_q;
    tx_sr_d    = tx_sr_q;
    rx_valid_d = 1'b0;
    if (!frame_active) begin
      bit_cnt_d = '0;
      rx_sr_d   = '0;
      tx_sr_d   = '0;
    end else if (rise) begin
      rx_sr_d    = {rx_sr_q[6:0], mosi_s[MSB]};
      bit_cnt_d  = bit_cnt_q + 3'd1;
      rx_valid_d = (bit_cnt_q == 3'd7);
    end else if (fall) begin
      // a fresh byte is loaded on the first falling edge after a byte boundary
      tx_sr_d = (bit_cnt_q == 3'd0) ? tx_byte : {tx_sr_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q  <= '0;
      rx_sr_q    <= '0;
      tx_sr_q    <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      bit_cnt_q  <= bit_cnt_d;
      rx_sr_q    <= rx_sr_d;
      tx_sr_q    <= tx_sr_d;
      rx_valid_q <= rx_valid_d;
    end
  end

  assign miso     = tx_sr_q[7];
  assign rx_valid = rx_valid_q;
  assign rx_byte  = rx_sr_q;
endmodule

// File: rtl/sprt_reg_store.sv
module sprt_reg_store
  import sprt_pkg::*;
#(
  parameter int NUM_PAGES     = 4,
  parameter int REGS_PER_PAGE = 8,
  parameter int FETCH_LAT     = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_page,
  input  logic [7:0]        wr_off,
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [7:0]        wr_data,
  input  logic              rd_start,
  input  logic [7:0]        rd_page,
  input  logic [7:0]        rd_off,
  output logic              rd_busy,
  output logic              rd_done,
  output logic [WIN_W-1:0]  rd_data
);
  localparam int DEPTH = NUM_PAGES * REGS_PER_PAGE;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(FETCH_LAT + 1);

  function automatic logic hit(input logic [7:0] pg, input logic [7:0] off);
    return ({24'd0, pg} < 32'(NUM_PAGES)) && ({24'd0, off} < 32'(REGS_PER_PAGE));
  endfunction

  function automatic logic [IDX_W-1:0] index(input logic [7:0] pg, input logic [7:0] off);
    return IDX_W'({24'd0, pg} * 32'(REGS_PER_PAGE) + {24'd0, off});
  endfunction

  logic [WIN_W-1:0] mem_q [DEPTH];
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             hit_q, hit_d;
  logic             wr_hit;
  logic [IDX_W-1:0] wr_idx;

  assign wr_hit = wr_en && hit(wr_page, wr_off);
  assign wr_idx = index(wr_page, wr_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_hit) begin
      mem_q[wr_idx][{wr_lane, 3'b000} +: 8] <= wr_data;
    end
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    hit_d  = hit_q;
    if (rd_start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(FETCH_LAT);
      idx_d  = index(rd_page, rd_off);
      hit_d  = hit(rd_page, rd_off);
    end else if (busy_q) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      hit_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      hit_q  <= hit_d;
    end
  end

  assign rd_busy = busy_q;
  assign rd_done = busy_q && (cnt_q == CNT_W'(1)) && !rd_start;
  assign rd_data = hit_q ? mem_q[idx_q] : '0;
endmodule

// File: rtl/spi_paged_regtarget.sv
module spi_paged_regtarget
  import sprt_pkg::*;
#(
  parameter int NUM_PAGES     = 4,
  parameter int REGS_PER_PAGE = 8,
  parameter int FETCH_LAT     = 300,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  localparam int IDX_W = $clog2(WIN_BYTES + 4);
  localparam logic [IDX_W-1:0] IDX_SAT = IDX_W'(WIN_BYTES + 3);
  localparam logic [IDX_W-1:0] WIN_LIM = IDX_W'(WIN_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  logic             frame_active, rx_valid;
  logic [7:0]       rx_byte, tx_byte;
  logic             fetch_start, fetch_busy, fetch_done;
  logic [WIN_W-1:0] fetch_data;
  logic             st_wr_en;

  logic [IDX_W-1:0] idx_q, idx_d, data_pos;
  logic             cmd_ok_q, cmd_ok_d;
  logic             wr_q, wr_d;
  logic [7:0]       off_q, off_d;
  rsp_sel_e         rsp_q, rsp_d;
  logic [7:0]       page_q, page_d;
  logic             rack_q, rack_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [7:0]       status;

  sprt_spi_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk         (clk),
    .rst_n       (rst_ni),
    .sclk        (spi_sclk),
    .cs_n        (spi_cs_n),
    .mosi        (spi_mosi),
    .tx_byte     (tx_byte),
    .miso        (spi_miso),
    .frame_active(frame_active),
    .rx_valid    (rx_valid),
    .rx_byte     (rx_byte)
  );

  sprt_reg_store #(
    .NUM_PAGES    (NUM_PAGES),
    .REGS_PER_PAGE(REGS_PER_PAGE),
    .FETCH_LAT    (FETCH_LAT)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_en   (st_wr_en),
    .wr_page (page_q),
    .wr_off  (off_q),
    .wr_lane (data_pos[LANE_W-1:0]),
    .wr_data (rx_byte),
    .rd_start(fetch_start),
    .rd_page (page_q),
    .rd_off  (rx_byte),
    .rd_busy (fetch_busy),
    .rd_done (fetch_done),
    .rd_data (fetch_data)
  );

  assign data_pos = idx_q - IDX_W'(2);

  // frame decoder
  always_comb begin
    idx_d       = idx_q;
    cmd_ok_d    = cmd_ok_q;
    wr_d        = wr_q;
    off_d       = off_q;
    rsp_d       = rsp_q;
    page_d      = page_q;
    fetch_start = 1'b0;
    st_wr_en    = 1'b0;
    if (!frame_active) begin
      idx_d    = '0;
      cmd_ok_d = 1'b0;
      rsp_d    = RSP_NONE;
    end else if (rx_valid) begin
      if (idx_q != IDX_SAT) idx_d = idx_q + IDX_W'(1);
      if (idx_q == IDX_W'(0)) begin
        cmd_ok_d = (rx_byte[7:1] == CMD_BASE[7:1]);
        wr_d     = rx_byte[0];
      end else if (idx_q == IDX_W'(1)) begin
        off_d = rx_byte;
        if (cmd_ok_q && !wr_q) begin
          if (rx_byte == OFF_PAGE)      rsp_d = RSP_PAGE;
          else if (rx_byte == OFF_STAT) rsp_d = RSP_STAT;
          else if (rx_byte == OFF_WIN)  rsp_d = RSP_WIN;
          else                          rsp_d = RSP_NONE;
          fetch_start = is_plain(rx_byte);
        end
      end else if (cmd_ok_q && wr_q) begin
        if (off_q == OFF_PAGE) begin
          if (idx_q == IDX_W'(2)) page_d = rx_byte;
        end else if (is_plain(off_q) && (data_pos < WIN_LIM)) begin
          st_wr_en = 1'b1;
        end
      end
    end
  end

  always_comb begin
    rack_d = rack_q;
    if (fetch_start)     rack_d = 1'b0;
    else if (fetch_done) rack_d = 1'b1;
    win_d = fetch_done ? fetch_data : win_q;
  end

  always_comb begin
    status                = '0;
    status[STAT_BUSY_BIT] = fetch_busy;
    status[STAT_ACK_BIT]  = rack_q;
  end

  always_comb begin
    unique case (rsp_q)
      RSP_PAGE: tx_byte = page_q;
      RSP_STAT: tx_byte = status;
      RSP_WIN:  tx_byte = (rack_q && (data_pos < WIN_LIM))
                          ? win_q[{data_pos[LANE_W-1:0], 3'b000} +: 8] : 8'h00;
      default:  tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      cmd_ok_q <= 1'b0;
      wr_q     <= 1'b0;
      off_q    <= '0;
      rsp_q    <= RSP_NONE;
      page_q   <= '0;
      rack_q   <= 1'b0;
      win_q    <= '0;
    end else begin
      idx_q    <= idx_d;
      cmd_ok_q <= cmd_ok_d;
      wr_q     <= wr_d;
      off_q    <= off_d;
      rsp_q    <= rsp_d;
      page_q   <= page_d;
      rack_q   <= rack_d;
      win_q    <= win_d;
    end
  end
endmodule

// File: rtl/sprt_checker.sv
module sprt_checker (
  input logic       clk,
  input logic       rst_ni,
  input logic       fetch_busy,
  input logic       rack,
  input logic       fetch_done,
  input logic       fetch_start,
  input logic       frame_active,
  input logic       miso,
  input logic       rx_valid,
  input logic [7:0] page
);
  p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !(fetch_busy && rack));

  p_start_clears_ack_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    fetch_start |=> (fetch_busy && !rack));

  p_done_sets_ack_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    fetch_done |=> (rack && !fetch_busy));

  p_idle_miso_low_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !frame_active |=> !miso);

  p_page_needs_byte_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    !rx_valid |=> $stable(page));
endmodule

bind spi_paged_regtarget sprt_checker u_chk (
  .clk         (clk),
  .rst_ni      (rst_ni),
  .fetch_busy  (fetch_busy),
  .rack        (rack_q),
  .fetch_done  (fetch_done),
  .fetch_start (fetch_start),
  .frame_active(frame_active),
  .miso        (spi_miso),
  .rx_valid    (rx_valid),
  .page        (page_q)
);

// File: tb/spi_paged_regtarget_tb_top.sv
module spi_paged_regtarget_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int LAT        = 300;

  logic clk, rst_n, sclk, cs_n, mosi, miso;
  int checks, errors;
  bit done;

  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] tbuf [12];

  spi_paged_regtarget #(.FETCH_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [7:0] got, input logic [7:0] want, input string tag);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, want);
    end
  endtask

  task automatic expect_b(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      idle(HALF);
      r[i] = miso;
      sclk = 1'b1;
      idle(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic [7:0] cmd, input logic [7:0] off, input int n, input bit cap);
    logic [7:0] r;
    cs_n = 1'b0;
    idle(HALF);
    send_byte(cmd, r);
    send_byte(off, r);
    for (int k = 0; k < n; k++) begin
      send_byte(tbuf[k], r);
      if (cap) got_q.push_back(r);
    end
    idle(HALF);
    cs_n = 1'b1;
    mosi = 1'b0;
    idle(4 * HALF);
  endtask

  task automatic wr1(input logic [7:0] off, input logic [7:0] v);
    tbuf[0] = v;
    frame(8'h61, off, 1, 1'b0);
  endtask

  task automatic rd(input logic [7:0] off, input int n);
    for (int k = 0; k < 12; k++) tbuf[k] = 8'h00;
    frame(8'h60, off, n, 1'b1);
  endtask

  task automatic fetch(input logic [7:0] off);
    frame(8'h60, off, 0, 1'b0);
  endtask

  // monitor: pairs captured bytes with expected ones
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(g, e, t);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    for (int k = 0; k < 12; k++) tbuf[k] = 8'h00;
    idle(5);
    rst_n = 1'b1;
    idle(5);

    check({7'd0, miso}, 8'h00, "R9 reset miso");
    expect_b(8'h00, "R3 reset status");
    rd(8'hFE, 1);

    // R2 page select and read-back
    wr1(8'hFF, 8'h01);
    expect_b(8'h01, "R2 page readback");
    rd(8'hFF, 1);

    // R8 full-width write, R4 busy, R5 ack, R6 window order
    for (int k = 0; k < 8; k++) tbuf[k] = 8'((k + 1) * 17);
    frame(8'h61, 8'h03, 8, 1'b0);
    fetch(8'h03);
    expect_b(8'h80, "R4 busy during fetch");
    rd(8'hFE, 1);
    idle(LAT + 100);
    expect_b(8'h20, "R5 ack after fetch");
    rd(8'hFE, 1);
    for (int k = 0; k < 8; k++) expect_b(8'((k + 1) * 17), "R6 window byte");
    expect_b(8'h00, "R6 ninth byte");
    expect_b(8'h00, "R6 tenth byte");
    rd(8'hF0, 10);

    // R8 partial write keeps upper lanes; R7 window blank while fetch pending
    tbuf[0] = 8'hAA; tbuf[1] = 8'hBB;
    frame(8'h61, 8'h03, 2, 1'b0);
    fetch(8'h03);
    expect_b(8'h00, "R7 window before ack");
    expect_b(8'h00, "R7 window before ack");
    rd(8'hF0, 2);
    idle(LAT + 100);
    expect_b(8'hAA, "R8 lane0"); expect_b(8'hBB, "R8 lane1");
    expect_b(8'h33, "R8 lane2 kept"); expect_b(8'h44, "R8 lane3 kept");
    rd(8'hF0, 4);

    // R8 bytes past the eighth are dropped
    for (int k = 0; k < 10; k++) tbuf[k] = 8'(k + 1);
    frame(8'h61, 8'h04, 10, 1'b0);
    fetch(8'h04);
    idle(LAT + 100);
    for (int k = 0; k < 8; k++) expect_b(8'(k + 1), "R8 no wrap");
    rd(8'hF0, 8);

    // R1 bad command bytes
    tbuf[0] = 8'hEE;
    frame(8'h41, 8'h04, 1, 1'b0);
    fetch(8'h04);
    idle(LAT + 100);
    expect_b(8'h01, "R1 bad write ignored");
    rd(8'hF0, 1);
    for (int k = 0; k < 12; k++) tbuf[k] = 8'h00;
    expect_b(8'h00, "R1 bad read returns zero");
    frame(8'h20, 8'hFF, 1, 1'b1);

    // R11 writes to status and window have no effect
    wr1(8'hF0, 8'h55);
    wr1(8'hFE, 8'hFF);
    expect_b(8'h01, "R11 window kept");
    rd(8'hF0, 1);
    expect_b(8'h20, "R11 status kept");
    rd(8'hFE, 1);

    // R2 page isolation: page 0 offset 3 untouched
    wr1(8'hFF, 8'h00);
    fetch(8'h03);
    idle(LAT + 100);
    expect_b(8'h00, "R2 other page"); expect_b(8'h00, "R2 other page");
    rd(8'hF0, 2);

    // R10 out-of-range page and offset
    wr1(8'hFF, 8'h07);
    wr1(8'h02, 8'h99);
    fetch(8'h02);
    idle(LAT + 100);
    expect_b(8'h20, "R10 fetch completes");
    rd(8'hFE, 1);
    expect_b(8'h00, "R10 page out of range");
    rd(8'hF0, 1);
    wr1(8'hFF, 8'h00);
    wr1(8'h09, 8'h77);
    fetch(8'h09);
    idle(LAT + 100);
    expect_b(8'h00, "R10 offset out of range");
    rd(8'hF0, 1);

    // R9 aborted frame resets the byte position
    cs_n = 1'b0;
    idle(HALF);
    begin
      logic [7:0] r;
      send_byte(8'h61, r);
    end
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1; idle(HALF); sclk = 1'b1; idle(HALF); sclk = 1'b0;
    end
    idle(HALF);
    cs_n = 1'b1;
    idle(4 * HALF);
    wr1(8'hFF, 8'h02);
    expect_b(8'h02, "R9 frame restart");
    rd(8'hFF, 1);
    check({7'd0, miso}, 8'h00, "R9 idle miso");

    idle(20);
    checks++;
    if (exp_q.size() != 0 || got_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d leftover expected 0", exp_q.size() + got_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule